// File: doc/BRIEF.md
# SPI Clock Rate Generator

This block turns the clock-rate field of an SPI controller's configuration into a train of single-cycle enable pulses, one for every SCK transition, which a separate shift engine uses to toggle the serial clock and move data. Software picks the field value; the block does no rate arithmetic of its own. A static variant input selects between two field encodings. The compact encoding gives an even divisor. The wide encoding gives a 4-bit mantissa scaled by a power of two, with the 3-bit exponent split across two separate places in the field.

The decoded rate is captured into a holding register only while the shift engine reports idle, so a word always runs at one rate. A restart input rewinds the half-period counter. The first SCK edge of a word then lands exactly one leading half-period after the restart. Every pulse is tagged as either the edge that ends the leading half of an SCK period or the one that ends the trailing half. For odd divisors the leading half is the longer one.

Top module: `sck_rate_gen`

## Requirements
- R1: With `ext_mode`=1 the SCK period D is M·2^E core cycles, where the mantissa M = `rate_field[3:0]` and the exponent E = {`rate_field[7]`, `rate_field[6]`, `rate_field[4]`} (bit 4 is the exponent LSB).
- R2: With `ext_mode`=1, `rate_field[5]` has no effect on the generated pulses.
- R3: With `ext_mode`=0, the field is valid only when `rate_field[4]`=1, and D = 2·`rate_field[3:0]`; `rate_field[7:5]` have no effect.
- R4: A field with `rate_field[4]`=0 in compact mode, with M=0 in wide mode, or that gives D<2, is invalid, and no pulses are produced while it is held.
- R5: After `busy` rises (cycle 1 is the first cycle `busy` is high), the first pulse comes in cycle ceil(D/2) with `sck_lead`=1, and the second comes in cycle D with `sck_lead`=0.
- R6: No pulse is produced while `busy` is low.
- R7: Field or mode changes while `busy` is high do not alter the running rate; the new value takes effect once `busy` has been low across a clock edge.
- R8: No pulse is produced in a cycle with `restart` high. The next pulse comes ceil(D/2) cycles after that cycle and has `sck_lead`=1.
- R9: During reset, and after reset until a field has been captured while idle, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | Static encoding select: 1 = mantissa/exponent, 0 = even divisor |
| rate_field | input | 8 | Clock-rate field from the configuration register |
| busy | input | 1 | Shift engine active; low allows the rate to be reloaded |
| restart | input | 1 | Rewind the half-period counter to the start of a word |
| sck_edge | output | 1 | One-cycle enable for an SCK transition |
| sck_lead | output | 1 | High with `sck_edge` when the pulse ends the leading half-period |

## Verification
The pulses come from a combinational decode of registered counter state, so a pulse is visible in the same cycle that its count is reached. The first pulse is due in the ceil(D/2)-th cycle of `busy`, the second in the D-th cycle, and after a restart the next one is due ceil(D/2) cycles after the restart cycle. A new field needs one idle clock edge before it is captured. The bench therefore drives inputs just after the falling edge, waits two idle edges before each run, and counts cycles from the first high `busy` cycle, sampling each cycle one nanosecond after the falling edge. Every field value in both encodings is swept, and the cycle index of each observed pulse is compared with ceil(D/2) and D computed in the bench.

// File: rtl/sck_rate_pkg.sv
package sck_rate_pkg;

    localparam int FIELD_W    = 8;
    localparam int MANT_W     = 4;
    localparam int EXP_W      = 3;
    // Field positions that software encodes; fixed by the register layout.
    localparam int EXP_LO_BIT = 4;   // exponent bit 0 / compact-mode valid bit
    localparam int EXP_HI_LSB = 6;   // exponent bits [2:1]
    localparam int DIV_W      = MANT_W + (1 << EXP_W) - 1;

    typedef logic [DIV_W-1:0] div_t;

    typedef struct packed {
        logic ok;
        div_t lead_len;
        div_t trail_len;
    } sck_cfg_t;

    // Split a full-period divisor into two half-periods, the leading one
    // taking the extra cycle of an odd divisor.
    function automatic sck_cfg_t split_divisor(input div_t d);
        sck_cfg_t c;
        c.ok        = (d >= div_t'(2));
        c.trail_len = d >> 1;
        c.lead_len  = (d >> 1) + div_t'(d[0]);
        return c;
    endfunction

endpackage

// File: rtl/sck_field_decode.sv
module sck_field_decode
    import sck_rate_pkg::*;
(
    input  logic               ext_mode,
    input  logic [FIELD_W-1:0] field,
    output sck_cfg_t           cfg
);

    logic [MANT_W-1:0] mant;
    logic [EXP_W-1:0]  expo;
    div_t              divisor;
    logic              unused_width_bit;

    assign mant             = field[MANT_W-1:0];
    assign expo             = {field[EXP_HI_LSB +: EXP_W-1], field[EXP_LO_BIT]};
    assign unused_width_bit = field[EXP_LO_BIT+1];

    always_comb begin
        if (ext_mode) begin
            divisor = div_t'(mant) << expo;
        end else if (field[EXP_LO_BIT]) begin
            divisor = div_t'(mant) << 1;
        end else begin
            divisor = '0;
        end
        cfg = split_divisor(divisor);
    end

endmodule

// File: rtl/sck_half_counter.sv
module sck_half_counter
    import sck_rate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     clear,
    input  sck_cfg_t cfg,
    output logic     edge_o,
    output logic     lead_o
);

    div_t cnt_q;
    logic trail_q;   // 0 = in leading half, 1 = in trailing half
    div_t cur_len;
    logic at_end;

    assign cur_len = trail_q ? cfg.trail_len : cfg.lead_len;
    assign at_end  = (cnt_q == cur_len - div_t'(1));
    assign edge_o  = run && !clear && cfg.ok && at_end;
    assign lead_o  = edge_o && !trail_q;

    always_ff @(posedge clk) begin
        if (rst || !run || clear) begin
            cnt_q   <= '0;
            trail_q <= 1'b0;
        end else if (cfg.ok) begin
            if (at_end) begin
                cnt_q   <= '0;
                trail_q <= !trail_q;
            end else begin
                cnt_q   <= cnt_q + div_t'(1);
            end
        end
    end

endmodule

// File: rtl/sck_rate_gen.sv
module sck_rate_gen
    import sck_rate_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ext_mode,
    input  logic [FIELD_W-1:0] rate_field,
    input  logic               busy,
    input  logic               restart,
    output logic               sck_edge,
    output logic               sck_lead
);

    sck_cfg_t dec_cfg;
    sck_cfg_t cfg_q;

    sck_field_decode u_decode (
        .ext_mode (ext_mode),
        .field    (rate_field),
        .cfg      (dec_cfg)
    );

    // Rate is captured only between words.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (!busy) begin
            cfg_q <= dec_cfg;
        end
    end

    sck_half_counter u_count (
        .clk    (clk),
        .rst    (rst),
        .run    (busy),
        .clear  (restart),
        .cfg    (cfg_q),
        .edge_o (sck_edge),
        .lead_o (sck_lead)
    );

endmodule

// File: rtl/sck_rate_chk.sv
module sck_rate_chk
    import sck_rate_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     busy,
    input logic     restart,
    input logic     sck_edge,
    input sck_cfg_t cfg_q
);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck_edge);

    assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        restart |-> !sck_edge);

    assert_invalid_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.ok |-> !sck_edge);

    assert_rate_held_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(busy)) |-> $stable(cfg_q));

endmodule

bind sck_rate_gen sck_rate_chk u_sck_rate_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .restart  (restart),
    .sck_edge (sck_edge),
    .cfg_q    (cfg_q)
);

// File: tb/test_sck_rate_gen.sv
module test_sck_rate_gen;

    logic       clk = 1'b0;
    logic       rst;
    logic       ext_mode;
    logic [7:0] rate_field;
    logic       busy;
    logic       restart;
    logic       sck_edge;
    logic       sck_lead;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    sck_rate_gen i_sck_rate_gen (
        .clk        (clk),
        .rst        (rst),
        .ext_mode   (ext_mode),
        .rate_field (rate_field),
        .busy       (busy),
        .restart    (restart),
        .sck_edge   (sck_edge),
        .sck_lead   (sck_lead)
    );

    task automatic chk(input string tag, input int fld, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s field=%02h actual=%0d expected=%0d", tag, fld, act, exp_v);
        end
    endtask

    // Expected divisor from the requirement encodings (R1, R3, R4).
    function automatic int exp_div(input int m, input int f);
        int mant, ex;
        mant = f % 16;
        if (m == 1) begin
            ex = ((f >> 6) & 3) * 2 + ((f >> 4) & 1);
            return mant * (1 << ex);
        end
        return ((f >> 4) & 1) ? 2 * mant : 0;
    endfunction

    // Called right after a falling edge; cycle 1 is the first busy cycle.
    task automatic measure(input int win, output int n, output int p1, output int p2,
                           output int l1, output int l2);
        n = 0; p1 = 0; p2 = 0; l1 = 0; l2 = 0;
        busy = 1'b1;
        for (int k = 1; k <= win; k++) begin
            #1;
            if (sck_edge) begin
                n++;
                if (n == 1) begin p1 = k; l1 = int'(sck_lead); end
                else if (n == 2) begin p2 = k; l2 = int'(sck_lead); end
            end
            @(negedge clk);
        end
        busy = 1'b0;
    endtask

    task automatic load_idle(input int m, input int f);
        @(negedge clk);
        busy       = 1'b0;
        ext_mode   = m[0];
        rate_field = f[7:0];
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int n, p1, p2, l1, l2, d, h;
        string tag;
        rst = 1'b1; busy = 1'b1; ext_mode = 1'b1; rate_field = 8'h05; restart = 1'b0;

        // R9: no pulses during reset
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            chk("R9", 5, int'(sck_edge), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        // R9: nothing captured yet because busy stayed high
        for (int k = 0; k < 10; k++) begin
            #1;
            chk("R9", 5, int'(sck_edge), 0);
            @(negedge clk);
        end

        // Exhaustive sweep of both encodings
        for (int m = 0; m < 2; m++) begin
            for (int f = 0; f < 256; f++) begin
                d = exp_div(m, f);
                load_idle(m, f);
                if (d < 2) begin
                    measure(40, n, p1, p2, l1, l2);
                    chk("R4", f, n, 0);
                end else begin
                    h = (d + 1) / 2;
                    tag = (m == 0) ? "R3" : (((f >> 5) & 1) ? "R2" : "R1");
                    measure(d, n, p1, p2, l1, l2);
                    chk(tag, f, n, 2);
                    chk(tag, f, p2, d);
                    chk("R5", f, p1, h);
                    chk("R5", f, l1, 1);
                    chk("R5", f, l2, 0);
                end
            end
        end

        // R6: valid rate captured, busy held low
        load_idle(0, 8'h12);
        n = 0;
        for (int k = 0; k < 20; k++) begin
            #1;
            if (sck_edge) n++;
            @(negedge clk);
        end
        chk("R6", 8'h12, n, 0);

        // R7: field changed at the moment busy rises keeps old rate (D=5)
        load_idle(1, 8'h05);
        rate_field = 8'h0F;
        measure(5, n, p1, p2, l1, l2);
        chk("R7", 8'h0F, p1, 3);
        chk("R7", 8'h0F, p2, 5);
        // after an idle edge the new rate (D=15) applies
        @(negedge clk);
        @(negedge clk);
        measure(15, n, p1, p2, l1, l2);
        chk("R7", 8'h0F, p1, 8);
        chk("R7", 8'h0F, p2, 15);
        // R7: mode change while busy ignored (compact 0x13 would be D=6 vs wide D=3*2=6 -> use 0x1A)
        load_idle(1, 8'h1A);   // wide: M=10, E=1 -> D=20
        ext_mode = 1'b0;       // compact would give D=20 as well; use field change too
        rate_field = 8'h12;    // compact D=4 if it were applied
        measure(20, n, p1, p2, l1, l2);
        chk("R7", 8'h12, p1, 10);
        chk("R7", 8'h12, p2, 20);

        // R8: restart in a cycle where a trailing pulse would fall (D=6)
        load_idle(0, 8'h13);
        busy = 1'b1;
        n = 0; p1 = 0;
        for (int k = 1; k <= 5; k++) begin
            #1;
            if (sck_edge) begin n++; p1 = k; end
            @(negedge clk);
        end
        chk("R8", 8'h13, p1, 3);
        restart = 1'b1;
        #1;
        chk("R8", 8'h13, int'(sck_edge), 0);
        @(negedge clk);
        restart = 1'b0;
        n = 0; p1 = 0; l1 = 0;
        for (int k = 1; k <= 3; k++) begin
            #1;
            if (sck_edge) begin
                n++;
                if (n == 1) begin p1 = k; l1 = int'(sck_lead); end
            end
            @(negedge clk);
        end
        busy = 1'b0;
        chk("R8", 8'h13, n, 1);
        chk("R8", 8'h13, p1, 3);
        chk("R8", 8'h13, l1, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule